// File: doc/BRIEF.md
# Universal Shift Register with J/K-bar Serial Entry

This block is a clocked register of parameterized width (four stages by default) with two operating modes chosen by an active-low load select. With the load select low, every stage captures its own parallel data bit on the rising clock edge. With the load select high, the contents move one stage toward the higher-numbered end on each edge. Stage 0 is then fed by a J input and an active-low K input. That pair can clear the stage, hold it, toggle it or set it. Wiring J and K together turns it into a plain serial data input.

An active-low asynchronous reset clears every stage at once. A complemented copy of the last stage is provided beside the parallel outputs. A shift toward stage 0 needs no mode of its own. The user wires each output to the parallel input one position below it and holds the load select low.

Top module: `ushift_reg`

## Requirements
- R1: While `rst_n` is low, `q_out` is all zeros, and it becomes zero as soon as `rst_n` falls, without waiting for a clock edge.
- R2: On a rising edge with `load_n` low, `q_out[n]` takes `par_in[n]` for every stage n.
- R3: On a rising edge with `load_n` high, `q_out[n]` takes the old `q_out[n-1]` for every n from 1 to WIDTH-1.
- R4: In shift mode, with `ser_j`=0 and `ser_kn`=0, stage 0 becomes 0.
- R5: In shift mode, with `ser_j`=0 and `ser_kn`=1, stage 0 keeps its old value.
- R6: In shift mode, with `ser_j`=1 and `ser_kn`=0, stage 0 becomes the inverse of its old value.
- R7: In shift mode, with `ser_j`=1 and `ser_kn`=1, stage 0 becomes 1.
- R8: `q_last_n` always equals the inverse of `q_out[WIDTH-1]`, so it is 1 during reset.
- R9: The first rising edge after `rst_n` is released performs a normal load or shift, starting from the all-zero state.
- R10: Holding `load_n` low with `par_in[n]` wired to `q_out[n+1]` (and `par_in[WIDTH-1]` fed externally) moves the contents one stage toward stage 0 per edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all transfers occur on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears every stage |
| load_n | input | 1 | Mode select: 0 = parallel load, 1 = shift up |
| ser_j | input | 1 | J input of stage 0 in shift mode |
| ser_kn | input | 1 | Active-low K input of stage 0 in shift mode |
| par_in | input | WIDTH | Parallel data, one bit per stage |
| q_out | output | WIDTH | Register contents |
| q_last_n | output | 1 | Inverse of the last stage |

## Verification
The checker tests on every clock edge that the complement output tracks the last stage, that a load copies the sampled parallel word, that a shift moves each stage up by one, that each of the four J/K codes gives its own stage-0 result, and that the register reads zero while reset is held. Three behaviours come only from the bench's scenarios: that a reset dropped in the middle of a clock period clears the outputs at once, that the first edge after release acts normally, and that the external wiring for a downward shift works. The bench also runs random mode, J/K and data sequences against its own model.

// File: rtl/usr_pkg.sv
package usr_pkg;

    // Action of stage 0 in shift mode, encoded as {J, K-bar}
    typedef enum logic [1:0] {
        JK_CLEAR  = 2'b00,
        JK_HOLD   = 2'b01,
        JK_TOGGLE = 2'b10,
        JK_SET    = 2'b11
    } jk_act_e;

    function automatic logic jk_apply(input jk_act_e act, input logic cur);
        logic res;
        case (act)
            JK_CLEAR:  res = 1'b0;
            JK_HOLD:   res = cur;
            JK_TOGGLE: res = ~cur;
            default:   res = 1'b1;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/usr_first_stage.sv
module usr_first_stage
    import usr_pkg::*;
(
    input  logic j_in,
    input  logic kn_in,
    input  logic cur_bit,
    output logic nxt_bit
);
    jk_act_e act;

    always_comb begin
        act     = jk_act_e'({j_in, kn_in});
        nxt_bit = jk_apply(act, cur_bit);
    end
endmodule

// File: rtl/usr_next_mux.sv
module usr_next_mux #(
    parameter int WIDTH = 4
) (
    input  logic             load_n,
    input  logic [WIDTH-1:0] par_in,
    input  logic [WIDTH-1:0] cur,
    input  logic             stage0_shift,
    output logic [WIDTH-1:0] nxt
);
    // stage 0: parallel bit or J/K-bar result
    assign nxt[0] = load_n ? stage0_shift : par_in[0];

    // upper stages: parallel bit or the stage below
    for (genvar n = 1; n < WIDTH; n++) begin : g_stage
        assign nxt[n] = load_n ? cur[n-1] : par_in[n];
    end
endmodule

// File: rtl/ushift_reg.sv
module ushift_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             ser_j,
    input  logic             ser_kn,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q_out,
    output logic             q_last_n
);
    localparam int LAST = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] stages;
    } reg_s;

    reg_s             st_d, st_q;
    logic             s0_shift;
    logic [WIDTH-1:0] mux_nxt;

    usr_first_stage i_first (
        .j_in    (ser_j),
        .kn_in   (ser_kn),
        .cur_bit (st_q.stages[0]),
        .nxt_bit (s0_shift)
    );

    usr_next_mux #(.WIDTH(WIDTH)) i_mux (
        .load_n       (load_n),
        .par_in       (par_in),
        .cur          (st_q.stages),
        .stage0_shift (s0_shift),
        .nxt          (mux_nxt)
    );

    always_comb begin
        st_d        = st_q;
        st_d.stages = mux_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_out    = st_q.stages;
    assign q_last_n = ~st_q.stages[LAST];
endmodule

// File: rtl/ushift_reg_chk.sv
module ushift_reg_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_n,
    input logic             ser_j,
    input logic             ser_kn,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] q_out,
    input logic             q_last_n
);
    a_r1_zero_in_reset: assert property (@(posedge clk)
        !rst_n |-> q_out == '0);

    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> q_out == $past(par_in));

    if (WIDTH > 1) begin : g_up
        a_r3_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
            load_n |=> q_out[WIDTH-1:1] == $past(q_out[WIDTH-2:0]));
    end

    a_r4_jk_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !ser_j && !ser_kn) |=> !q_out[0]);

    a_r5_jk_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !ser_j && ser_kn) |=> q_out[0] == $past(q_out[0]));

    a_r6_jk_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && ser_j && !ser_kn) |=> q_out[0] != $past(q_out[0]));

    a_r7_jk_set: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && ser_j && ser_kn) |=> q_out[0]);

    a_r8_complement: assert property (@(posedge clk)
        q_last_n != q_out[WIDTH-1]);
endmodule

bind ushift_reg ushift_reg_chk #(.WIDTH(WIDTH)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_n   (load_n),
    .ser_j    (ser_j),
    .ser_kn   (ser_kn),
    .par_in   (par_in),
    .q_out    (q_out),
    .q_last_n (q_last_n)
);

// File: tb/test_ushift_reg.sv
`timescale 1ns/100ps
module test_ushift_reg;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_n = 1'b0;
    logic         ser_j = 1'b0;
    logic         ser_kn = 1'b0;
    logic [W-1:0] par_in = '0;
    logic [W-1:0] q_out;
    logic         q_last_n;

    int           checks = 0;
    int           errors = 0;
    logic [W-1:0] exp_q = '0;

    always #2 clk = ~clk;

    ushift_reg #(.WIDTH(W)) i_ushift_reg (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .ser_j(ser_j),
        .ser_kn(ser_kn), .par_in(par_in), .q_out(q_out), .q_last_n(q_last_n)
    );

    function automatic logic [W-1:0] model(input logic [W-1:0] cur,
        input logic ld, input logic j, input logic k, input logic [W-1:0] p);
        logic [W-1:0] n;
        if (!ld) return p;
        n = cur << 1;
        case ({j, k})
            2'b00: n[0] = 1'b0;
            2'b01: n[0] = cur[0];
            2'b10: n[0] = ~cur[0];
            default: n[0] = 1'b1;
        endcase
        return n;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic check_out(input string req);
        check(req, q_out, exp_q);
        check("R8", {{(W-1){1'b0}}, q_last_n}, {{(W-1){1'b0}}, ~exp_q[W-1]});
    endtask

    // one clock step; wire_dn wires par_in for a shift toward stage 0
    task automatic step(input logic ld, input logic j, input logic k,
        input logic [W-1:0] p, input logic wire_dn, input logic ext, input string req);
        logic [W-1:0] pv;
        @(negedge clk);
        pv = wire_dn ? {ext, q_out[W-1:1]} : p;
        load_n = ld; ser_j = j; ser_kn = k; par_in = pv;
        @(posedge clk);
        exp_q = model(exp_q, ld, j, k, pv);
        #1;
        check_out(req);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd5150));
        #1;
        check("R1", q_out, '0);
        check("R8", {{(W-1){1'b0}}, q_last_n}, {{(W-1){1'b0}}, 1'b1});
        #8 rst_n = 1'b1;
        exp_q = '0;

        // R9: first edge after release loads normally
        step(1'b0, 1'b0, 1'b0, 4'b1010, 1'b0, 1'b0, "R9");

        // R2: all parallel patterns
        for (int v = 0; v < 16; v++)
            step(1'b0, 1'b0, 1'b0, W'(v), 1'b0, 1'b0, "R2");

        // J/K combinations from both stage-0 values
        step(1'b0, 1'b0, 1'b0, 4'b0110, 1'b0, 1'b0, "R2");
        step(1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R4");
        step(1'b1, 1'b0, 1'b1, '0, 1'b0, 1'b0, "R5");
        step(1'b1, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R6");
        step(1'b1, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R6");
        step(1'b1, 1'b1, 1'b1, '0, 1'b0, 1'b0, "R7");
        step(1'b1, 1'b0, 1'b1, '0, 1'b0, 1'b0, "R5");
        step(1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R4");
        for (int i = 0; i < 6; i++)
            step(1'b1, 1'b1, 1'b1, '0, 1'b0, 1'b0, "R3");

        // R10: downward shift via external wiring
        step(1'b0, 1'b0, 1'b0, 4'b1001, 1'b0, 1'b0, "R2");
        for (int i = 0; i < 5; i++)
            step(1'b0, 1'b0, 1'b0, '0, 1'b1, i[0], "R10");

        // R1: reset dropped mid-cycle, then R9 on release
        step(1'b0, 1'b0, 1'b0, 4'b1111, 1'b0, 1'b0, "R2");
        #0.5 rst_n = 1'b0;
        #0.1;
        exp_q = '0;
        check_out("R1");
        @(posedge clk);
        #1;
        check_out("R1");
        rst_n = 1'b1;
        step(1'b1, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R9");

        // random traffic
        for (int i = 0; i < 400; i++) begin
            logic [3:0] r;
            r = 4'($urandom);
            step(r[0] | r[1], r[2], r[3], W'($urandom), 1'b0, 1'b0, "R3");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule